// File: doc/BRIEF.md
# Card Clock Divider with Glitch-Free Ratio Switching

This block derives the clock for a smart-card contact from a faster input clock. It divides by 8, 4, 2 or 1, as a two-bit select code chooses, and a sequencer gates the result with an enable. When the enable is low the card clock is low. Dropping the enable never cuts a high phase short: the current high phase completes and the output then stays low.

The select code may change while the card is clocked. The block first passes the code through a synchroniser. It accepts the code only after the synchronised value has held still for a settling interval. It then switches ratio only at the end of a complete high phase, and bridges the switch with a low stretch of at least eight input periods. Every pulse on either side of a switch therefore has its full width, and no pulse is shorter than the shortest legal phase. Divide-by-1 passes the input clock through a latch-based gate, so the first and last pulses are whole input-clock high phases.

There is no data stream, so the block has no valid/ready interface. The select code and the enable are plain level inputs, and the card clock is a plain output.

Top module: `card_clk_div`

## Requirements
- R1: While reset is asserted and after it is released, `card_clk_o` is low until the enable is raised. The initial ratio is divide-by-8, select code 00.
- R2: The select codes map as follows: 00 divides by 8, 01 by 4, 11 by 2 and 10 by 1. In steady state a divide-by-N ratio (N ≥ 2) gives N/2 input cycles high followed by N/2 cycles low.
- R3: A low enable holds the output low. If the enable falls during a high phase, that phase completes before the output goes low. Raising the enable starts a full high phase of the accepted ratio at the next input clock edge.
- R4: A select change that lands before input edge k is accepted at edge k+SYNC_STAGES+SETTLE_CYC, provided the code does not change again in the meantime. With the defaults this is 10 edges.
- R5: A code that appears at the select input for fewer than SETTLE_CYC cycles is never accepted. This includes an intermediate code that appears for one cycle. The output keeps its current ratio.
- R6: A ratio change while running is applied only after a complete high phase. The output then stays low for at least GAP_CYC input cycles, and the new ratio begins with a full high phase. A change accepted during a low phase lets that low phase and one more full high phase run at the old ratio first.
- R7: In divide-by-1 the output follows the input clock through a gate that opens and closes only while the input clock is low. Every emitted pulse is a whole high half of the input clock, and no divided pulse is produced at the same time.
- R8: A code accepted while the enable is low takes effect at once, with no low bridge, when the enable is next raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 2 | Ratio select code (00=/8, 01=/4, 11=/2, 10=/1); only one bit changes at a time |
| clk_en_i | input | 1 | Card clock enable from the activation sequencer |
| card_clk_o | output | 1 | Divided and gated card clock |

## Verification
A wrong phase counter or state shows up within one phase as a high or low run of the wrong length at `card_clk_o`. The reference model compares the output in both halves of every input cycle. A wrong settling count or synchroniser depth moves the first new-ratio pulse by a whole cycle, which the model sees at the switch-over. A gate that updates on the wrong clock level shows up in divide-by-1 as a missing, extra or partial pulse in the first or last half cycle around enabling, disabling or switching.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

  // Ratio codes: adjacent ratios differ in one bit
  typedef enum logic [1:0] {
    CK_DIV8 = 2'b00,
    CK_DIV4 = 2'b01,
    CK_DIV1 = 2'b10,
    CK_DIV2 = 2'b11
  } ck_ratio_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIGH,
    ST_LOW,
    ST_GAP,
    ST_ONE
  } ck_state_e;

  // Input cycles per half period; zero marks the pass-through ratio
  function automatic logic [2:0] half_len(ck_ratio_e r);
    case (r)
      CK_DIV8: half_len = 3'd4;
      CK_DIV4: half_len = 3'd2;
      CK_DIV2: half_len = 3'd1;
      default: half_len = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ckdiv_sel_filter.sv
module ckdiv_sel_filter
  import ckdiv_pkg::*;
#(
  parameter int        SYNC_STAGES = 2,
  parameter int        SETTLE_CYC  = 8,
  parameter ck_ratio_e RESET_CODE  = CK_DIV8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic [1:0] sel_i,
  output ck_ratio_e tgt_o
);

  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SW-1:0] STAB_TOP = SW'(SETTLE_CYC - 1);

  // Synchroniser chain, one register per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    logic [1:0] q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RESET_CODE;
        else         q <= sel_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RESET_CODE;
        else         q <= g_sync[g-1].q;
      end
    end
  end

  logic [1:0]    sel_s;
  logic [1:0]    sel_p;
  logic [SW-1:0] stab_q;
  ck_ratio_e     tgt_q;

  assign sel_s = g_sync[SYNC_STAGES-1].q;

  // Stability filter: accept a code once it has held for SETTLE_CYC samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_p  <= RESET_CODE;
      stab_q <= STAB_TOP;
      tgt_q  <= RESET_CODE;
    end else begin
      sel_p <= sel_s;
      if (sel_s != sel_p)        stab_q <= '0;
      else if (stab_q != STAB_TOP) stab_q <= stab_q + SW'(1);
      if ((sel_s == sel_p) && (stab_q == STAB_TOP)) tgt_q <= ck_ratio_e'(sel_s);
    end
  end

  assign tgt_o = tgt_q;

  AST_TGT_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(tgt_q) |-> ($past(sel_s) == $past(sel_s, 2))); // R4

endmodule

// File: rtl/ckdiv_seq.sv
module ckdiv_seq
  import ckdiv_pkg::*;
#(
  parameter int        GAP_CYC    = 8,
  parameter ck_ratio_e RESET_CODE = CK_DIV8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  ck_ratio_e tgt_i,
  output logic      out_o,
  output logic      run1_o
);

  localparam int MAXC = (GAP_CYC + 1 > 4) ? GAP_CYC + 1 : 4;
  localparam int CW   = $clog2(MAXC + 1);

  ck_state_e     st_q;
  ck_ratio_e     cur_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;
  logic          run1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= RESET_CODE;
      cnt_q  <= '0;
      out_q  <= 1'b0;
      run1_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cur_q <= tgt_i;
          if (en_i) begin
            if (tgt_i == CK_DIV1) begin
              st_q   <= ST_ONE;
              run1_q <= 1'b1;
            end else begin
              st_q  <= ST_HIGH;
              out_q <= 1'b1;
              cnt_q <= CW'(half_len(tgt_i)) - CW'(1);
            end
          end
        end
        ST_HIGH: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
          end else if (!en_i) begin
            st_q  <= ST_IDLE;
            out_q <= 1'b0;
          end else if (tgt_i != cur_q) begin
            st_q  <= ST_GAP;
            cur_q <= tgt_i;
            out_q <= 1'b0;
            cnt_q <= CW'(GAP_CYC - 1);
          end else begin
            st_q  <= ST_LOW;
            out_q <= 1'b0;
            cnt_q <= CW'(half_len(cur_q)) - CW'(1);
          end
        end
        ST_LOW: begin
          if (!en_i) begin
            st_q <= ST_IDLE;
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
          end else begin
            st_q  <= ST_HIGH;
            out_q <= 1'b1;
            cnt_q <= CW'(half_len(cur_q)) - CW'(1);
          end
        end
        ST_GAP: begin
          if (!en_i) begin
            st_q <= ST_IDLE;
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
          end else if (cur_q == CK_DIV1) begin
            st_q   <= ST_ONE;
            run1_q <= 1'b1;
          end else begin
            st_q  <= ST_HIGH;
            out_q <= 1'b1;
            cnt_q <= CW'(half_len(cur_q)) - CW'(1);
          end
        end
        ST_ONE: begin
          if (!en_i) begin
            st_q   <= ST_IDLE;
            run1_q <= 1'b0;
          end else if (tgt_i != cur_q) begin
            // one extra cycle covers the high half still passed by the gate
            st_q   <= ST_GAP;
            cur_q  <= tgt_i;
            run1_q <= 1'b0;
            cnt_q  <= CW'(GAP_CYC);
          end
        end
        default: begin
          st_q   <= ST_IDLE;
          out_q  <= 1'b0;
          run1_q <= 1'b0;
        end
      endcase
    end
  end

  assign out_o  = out_q;
  assign run1_o = run1_q;

  // Observation counters for the width checks below
  logic       act_d;
  logic       sw_flag;
  ck_ratio_e  cur_d;
  logic [3:0] hi_cnt;
  logic [7:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_d   <= 1'b0;
      sw_flag <= 1'b0;
      cur_d   <= RESET_CODE;
      hi_cnt  <= '0;
      lo_cnt  <= '0;
    end else begin
      act_d <= out_q | run1_q;
      cur_d <= cur_q;
      hi_cnt <= out_q ? hi_cnt + 4'd1 : 4'd0;
      if (out_q | run1_q)       lo_cnt <= '0;
      else if (lo_cnt != 8'hFF) lo_cnt <= lo_cnt + 8'd1;
      if (!en_i || ((out_q | run1_q) && !act_d)) sw_flag <= 1'b0;
      else if ((cur_q != cur_d) && act_d)        sw_flag <= 1'b1;
    end
  end

  AST_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_q) |-> (hi_cnt == 4'(half_len($past(cur_q))))); // R2

  AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !out_q && !run1_q) |=> (!out_q && !run1_q)); // R3

  AST_SWITCH_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_q | run1_q) && !act_d && sw_flag) |-> (lo_cnt >= 8'(GAP_CYC))); // R6

  AST_SWITCH_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(cur_q) |-> (!out_q && !run1_q)); // R6

endmodule

// File: rtl/ckdiv_gate.sv
module ckdiv_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_i,
  input  logic run1_i,
  output logic card_clk_o
);

  logic gate_l;

  // Gate enable changes only while the input clock is low
  always_latch begin
    if (!rst_ni)     gate_l = 1'b0;
    else if (!clk_i) gate_l = run1_i;
  end

  assign card_clk_o = (clk_i & gate_l) | out_i;

  AST_ONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run1_i |-> !out_i); // R7

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter int         SYNC_STAGES = 2,
  parameter int         SETTLE_CYC  = 8,
  parameter int         GAP_CYC     = 8,
  parameter logic [1:0] RESET_CODE  = 2'b00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] div_sel_i,
  input  logic       clk_en_i,
  output logic       card_clk_o
);

  import ckdiv_pkg::*;

  localparam ck_ratio_e RST_RATIO = ck_ratio_e'(RESET_CODE);

  ck_ratio_e tgt;
  logic      div_out;
  logic      run1;

  ckdiv_sel_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .SETTLE_CYC (SETTLE_CYC),
    .RESET_CODE (RST_RATIO)
  ) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (div_sel_i),
    .tgt_o (tgt)
  );

  ckdiv_seq #(
    .GAP_CYC   (GAP_CYC),
    .RESET_CODE(RST_RATIO)
  ) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (clk_en_i),
    .tgt_i (tgt),
    .out_o (div_out),
    .run1_o(run1)
  );

  ckdiv_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .out_i     (div_out),
    .run1_i    (run1),
    .card_clk_o(card_clk_o)
  );

  AST_RESET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !card_clk_o); // R1

endmodule

// File: tb/sim_card_clk_div.sv
module sim_card_clk_div;

  localparam int SYNC = 2;
  localparam int SETTLE = 8;
  localparam int GAP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       card_clk;

  int    checks = 0;
  int    fails = 0;
  string req = "R1";

  always #2 clk = ~clk;

  card_clk_div #(
    .SYNC_STAGES(SYNC), .SETTLE_CYC(SETTLE), .GAP_CYC(GAP), .RESET_CODE(2'b00)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_sel_i(sel), .clk_en_i(en), .card_clk_o(card_clk)
  );

  // Reference model: integers only
  int m_pipe[SYNC];
  int m_prev, m_run, m_acc;
  int m_mode, m_left, m_cur, m_out, m_pass, m_pass_prev;

  function automatic int half_of(int code);
    case (code)
      0: return 4;
      1: return 2;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic model_init();
    for (int i = 0; i < SYNC; i++) m_pipe[i] = 0;
    m_prev = 0; m_run = SETTLE - 1; m_acc = 0;
    m_mode = 0; m_left = 0; m_cur = 0; m_out = 0; m_pass = 0; m_pass_prev = 0;
  endtask

  task automatic model_step();
    int acc_old;
    int synced;
    acc_old = m_acc;
    synced = m_pipe[SYNC-1];
    if (synced == m_prev && m_run == SETTLE - 1) m_acc = synced;
    if (synced != m_prev) m_run = 0;
    else if (m_run < SETTLE - 1) m_run++;
    m_prev = synced;
    for (int i = SYNC - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
    m_pipe[0] = int'(sel);
    m_pass_prev = m_pass;
    case (m_mode)
      0: begin
        m_cur = acc_old;
        if (en) begin
          if (half_of(acc_old) == 0) begin m_mode = 4; m_pass = 1; end
          else begin m_mode = 1; m_out = 1; m_left = half_of(acc_old); end
        end
      end
      1: begin
        if (m_left > 1) m_left--;
        else if (!en) begin m_mode = 0; m_out = 0; end
        else if (acc_old != m_cur) begin
          m_mode = 3; m_cur = acc_old; m_out = 0; m_left = GAP;
        end else begin m_mode = 2; m_out = 0; m_left = half_of(m_cur); end
      end
      2: begin
        if (!en) m_mode = 0;
        else if (m_left > 1) m_left--;
        else begin m_mode = 1; m_out = 1; m_left = half_of(m_cur); end
      end
      3: begin
        if (!en) m_mode = 0;
        else if (m_left > 1) m_left--;
        else if (half_of(m_cur) == 0) begin m_mode = 4; m_pass = 1; end
        else begin m_mode = 1; m_out = 1; m_left = half_of(m_cur); end
      end
      default: begin
        if (!en) begin m_mode = 0; m_pass = 0; end
        else if (acc_old != m_cur) begin
          m_mode = 3; m_cur = acc_old; m_pass = 0; m_left = GAP + 1;
        end
      end
    endcase
  endtask

  task automatic check_bit(logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: card_clk=%0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_init();
    else model_step();
    #1;
    if (rst_n) check_bit(card_clk, logic'(m_out | m_pass_prev), "high half");
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) check_bit(card_clk, logic'(m_out), "low half");
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    model_init();
    wait_cyc(3);
    #1 check_bit(card_clk, 1'b0, "in reset"); // R1
    rst_n = 1'b1;
    req = "R1"; wait_cyc(6);
    req = "R3"; en = 1'b1; wait_cyc(40);           // enable at /8, R2 widths
    req = "R4"; sel = 2'b01; wait_cyc(50);         // /8 -> /4 switch, R6 bridge
    req = "R2"; sel = 2'b11; wait_cyc(40);         // /4 -> /2
    req = "R7"; sel = 2'b10; wait_cyc(40);         // /2 -> /1 gated path
    req = "R6"; sel = 2'b00; wait_cyc(50);         // /1 -> /8
    req = "R5"; sel = 2'b01; wait_cyc(1); sel = 2'b00; wait_cyc(30);
    sel = 2'b01; wait_cyc(SETTLE - 3); sel = 2'b00; wait_cyc(30);
    req = "R6"; sel = 2'b01; wait_cyc(14); sel = 2'b11; wait_cyc(40);
    req = "R3";
    for (int off = 0; off < 4; off++) begin
      sel = (off % 2 == 0) ? 2'b01 : 2'b00;
      en = 1'b1; wait_cyc(30 + off);
      en = 1'b0; wait_cyc(12);
    end
    req = "R8"; sel = 2'b01; wait_cyc(4); sel = 2'b11; wait_cyc(15);
    en = 1'b1; wait_cyc(20);
    req = "R7"; sel = 2'b10; wait_cyc(25);
    en = 1'b0; wait_cyc(5); en = 1'b1; wait_cyc(10);
    en = 1'b0; sel = 2'b00; wait_cyc(15); en = 1'b1; wait_cyc(20);
    sel = 2'b10; wait_cyc(20); en = 1'b0; wait_cyc(3); sel = 2'b11; wait_cyc(15);
    en = 1'b1; wait_cyc(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule